// File: doc/BRIEF.md
# Banked Sequencer Register File

This block is the indexed sequencer register bank of an SVGA-class display controller. Software first writes a register number to the index port, then reads or writes the chosen register through the data port. The bank holds a run-control register, a group of standard mode registers, a fixed identification register and two extended registers. The extended registers exist twice, as an "old" set and a "new" set.

The identification register does two jobs. Reading it returns a fixed chip code and switches the extended registers to the new set. Writing it switches them to the old set, and the written byte is dropped. Three registered outputs are decoded from the stored state. The first tells the sequencer whether it is held in reset. The second selects the doubled pixel clock. The third gives the display-memory bank number, which software stores with bit 1 inverted.

Top module: `seq_regfile`

## Requirements
- R1: After synchronous reset: seq_in_reset=0, clk_double=0, mem_bank equals 2 (the cleared register XOR 2), rdata=0, the index is 0, the old set is active, and every extended register in both sets reads 0.
- R2: A write with addr=0 loads wdata into the index register. A read with addr=0 returns the index. An access with addr=1 acts on the register the index names.
- R3: Index 0x00 is run control. A stored value whose bit 1 is 0 holds the sequencer in reset (seq_in_reset=1), so writing 1 enters reset and writing 3 returns to run. A read returns bits 1:0 of the stored value with the upper bits 0.
- R4: Indices 0x01 through 0x04 (STD_COUNT registers) each store a full byte on their own and read it back unchanged.
- R5: A read of index 0x0B returns CHIP_ID and makes the new set active from the next access onward.
- R6: A write to index 0x0B makes the old set active. Its data is discarded: a later read of 0x0B still returns CHIP_ID.
- R7: Indices 0x0D and 0x0E read and write only the active set. The inactive set keeps its values.
- R8: mem_bank equals the low BANK_W bits of the new-set 0x0E value XOR 2. Bits above BANK_W are ignored, and writes to the old-set 0x0E leave mem_bank unchanged.
- R9: clk_double equals bit 0 of the new-set 0x0D value. Writes to the old-set 0x0D leave clk_double unchanged.
- R10: Writes to any other index are ignored and leave all outputs unchanged. Reads of any other index return 0.
- R11: All outputs are registered. seq_in_reset, clk_double and mem_bank change on the clock edge that takes the data write. rdata is loaded on the edge that takes rd_en and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| addr | input | 1 | 0 = index port, 1 = data port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after rd_en |
| seq_in_reset | output | 1 | Sequencer held in reset |
| clk_double | output | 1 | Doubled pixel clock selected |
| mem_bank | output | BANK_W | Display memory bank number |

## Verification
The properties assume that wr_en and rd_en are never high in the same cycle, because the block gives no meaning to a combined read and write. The bench issues every access as a single-cycle strobe with an idle cycle after it, so this never happens. The properties also assume BANK_W is at least 2, so that the inverted bit exists in the output. The bench runs with the default width of 4.

// File: rtl/seqrf_pkg.sv
package seqrf_pkg;
  localparam int DW = 8;

  localparam logic [DW-1:0] IX_RUNCTL = 8'h00;
  localparam logic [DW-1:0] IX_STD_LO = 8'h01;
  localparam logic [DW-1:0] IX_CHIPID = 8'h0B;
  localparam logic [DW-1:0] IX_XCLK   = 8'h0D;
  localparam logic [DW-1:0] IX_XBANK  = 8'h0E;

  typedef enum logic {
    SET_OLD = 1'b0,
    SET_NEW = 1'b1
  } ext_set_e;

  typedef struct packed {
    logic          wr;
    logic          rd;
    logic [DW-1:0] idx;
    logic [DW-1:0] data;
  } seq_acc_t;
endpackage

// File: rtl/seqrf_index_port.sv
module seqrf_index_port
  import seqrf_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] idx_q,
  output seq_acc_t      acc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (wr_en && !addr) begin
      idx_q <= wdata;
    end
  end

  always_comb begin
    acc.wr   = wr_en && addr;
    acc.rd   = rd_en && addr;
    acc.idx  = idx_q;
    acc.data = wdata;
  end
endmodule

// File: rtl/seqrf_std_regs.sv
module seqrf_std_regs
  import seqrf_pkg::*;
#(
  parameter int STD_COUNT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  seq_acc_t      acc,
  output logic          rd_hit,
  output logic [DW-1:0] rd_val,
  output logic          seq_in_reset
);
  localparam logic [DW-1:0] IX_STD_HI = IX_STD_LO + DW'(STD_COUNT - 1);

  logic [1:0] runctl_q;
  logic [STD_COUNT-1:0][DW-1:0] std_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      runctl_q     <= 2'b11;
      seq_in_reset <= 1'b0;
    end else if (acc.wr && acc.idx == IX_RUNCTL) begin
      runctl_q     <= acc.data[1:0];
      seq_in_reset <= ~acc.data[1];
    end
  end

  for (genvar g = 0; g < STD_COUNT; g++) begin : g_std
    localparam logic [DW-1:0] MY_IX = IX_STD_LO + DW'(g);
    always_ff @(posedge clk) begin
      if (rst) begin
        std_q[g] <= '0;
      end else if (acc.wr && acc.idx == MY_IX) begin
        std_q[g] <= acc.data;
      end
    end
  end

  always_comb begin
    rd_hit = 1'b0;
    rd_val = '0;
    if (acc.idx == IX_RUNCTL) begin
      rd_hit = 1'b1;
      rd_val = {{(DW-2){1'b0}}, runctl_q};
    end else if (acc.idx >= IX_STD_LO && acc.idx <= IX_STD_HI) begin
      rd_hit = 1'b1;
      for (int k = 0; k < STD_COUNT; k++) begin
        if (acc.idx == IX_STD_LO + DW'(k)) rd_val = std_q[k];
      end
    end
  end
endmodule

// File: rtl/seqrf_ext_banks.sv
module seqrf_ext_banks
  import seqrf_pkg::*;
#(
  parameter int            BANK_W  = 4,
  parameter logic [DW-1:0] CHIP_ID = 8'hD3
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_acc_t          acc,
  output ext_set_e          set_sel,
  output logic              rd_hit,
  output logic [DW-1:0]     rd_val,
  output logic              clk_double,
  output logic [BANK_W-1:0] mem_bank
);
  localparam int NSETS = 2;
  localparam logic [BANK_W-1:0] FLIP = BANK_W'(2);

  logic [NSETS-1:0][DW-1:0] xclk_q;
  logic [NSETS-1:0][DW-1:0] xbnk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      set_sel <= SET_OLD;
    end else if (acc.idx == IX_CHIPID) begin
      if (acc.rd)      set_sel <= SET_NEW;
      else if (acc.wr) set_sel <= SET_OLD;
    end
  end

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    always_ff @(posedge clk) begin
      if (rst) begin
        xclk_q[s] <= '0;
        xbnk_q[s] <= '0;
      end else if (acc.wr && set_sel == ext_set_e'(s)) begin
        if (acc.idx == IX_XCLK)  xclk_q[s] <= acc.data;
        if (acc.idx == IX_XBANK) xbnk_q[s] <= acc.data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_double <= 1'b0;
      mem_bank   <= FLIP;
    end else if (acc.wr && set_sel == SET_NEW) begin
      if (acc.idx == IX_XCLK)  clk_double <= acc.data[0];
      if (acc.idx == IX_XBANK) mem_bank   <= acc.data[BANK_W-1:0] ^ FLIP;
    end
  end

  always_comb begin
    rd_hit = 1'b1;
    unique case (acc.idx)
      IX_CHIPID: rd_val = CHIP_ID;
      IX_XCLK:   rd_val = xclk_q[set_sel];
      IX_XBANK:  rd_val = xbnk_q[set_sel];
      default: begin
        rd_hit = 1'b0;
        rd_val = '0;
      end
    endcase
  end
endmodule

// File: rtl/seq_regfile.sv
module seq_regfile
  import seqrf_pkg::*;
#(
  parameter int          STD_COUNT = 4,
  parameter int          BANK_W    = 4,
  parameter logic [7:0]  CHIP_ID   = 8'hD3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              seq_in_reset,
  output logic              clk_double,
  output logic [BANK_W-1:0] mem_bank
);
  logic [DW-1:0] idx_q;
  seq_acc_t      acc;
  logic          std_hit;
  logic [DW-1:0] std_val;
  logic          ext_hit;
  logic [DW-1:0] ext_val;
  ext_set_e      set_sel;
  logic          bank_new;

  seqrf_index_port u_idx (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .wdata (wdata),
    .idx_q (idx_q),
    .acc   (acc)
  );

  seqrf_std_regs #(.STD_COUNT(STD_COUNT)) u_std (
    .clk          (clk),
    .rst          (rst),
    .acc          (acc),
    .rd_hit       (std_hit),
    .rd_val       (std_val),
    .seq_in_reset (seq_in_reset)
  );

  seqrf_ext_banks #(.BANK_W(BANK_W), .CHIP_ID(CHIP_ID)) u_ext (
    .clk        (clk),
    .rst        (rst),
    .acc        (acc),
    .set_sel    (set_sel),
    .rd_hit     (ext_hit),
    .rd_val     (ext_val),
    .clk_double (clk_double),
    .mem_bank   (mem_bank)
  );

  assign bank_new = (set_sel == SET_NEW);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (!addr)        rdata <= idx_q;
      else if (std_hit) rdata <= std_val;
      else if (ext_hit) rdata <= ext_val;
      else              rdata <= '0;
    end
  end
endmodule

// File: rtl/seqrf_chk.sv
module seqrf_chk #(
  parameter int         BANK_W  = 4,
  parameter logic [7:0] CHIP_ID = 8'hD3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic              addr,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic [7:0]        idx_q,
  input logic              bank_new,
  input logic              seq_in_reset,
  input logic              clk_double,
  input logic [BANK_W-1:0] mem_bank
);
  localparam logic [BANK_W-1:0] FLIP = BANK_W'(2);

  // R2
  idx_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr) |=> (idx_q == $past(wdata)));

  // R3
  run_enter_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr && idx_q == 8'h00 && !wdata[1]) |=> seq_in_reset);

  // R3
  run_leave_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr && idx_q == 8'h00 && wdata[1]) |=> !seq_in_reset);

  // R5
  id_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr && idx_q == 8'h0B) |=> (rdata == CHIP_ID && bank_new));

  // R6
  id_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr && idx_q == 8'h0B) |=> !bank_new);

  // R8
  bank_out_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr && idx_q == 8'h0E && bank_new)
      |=> (mem_bank == ($past(wdata[BANK_W-1:0]) ^ FLIP)));

  // R9
  old_clk_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr && idx_q == 8'h0D && !bank_new) |=> $stable(clk_double));

  // R10
  ignored_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr && idx_q > 8'h0E)
      |=> ($stable(mem_bank) && $stable(clk_double) && $stable(seq_in_reset)));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

bind seq_regfile seqrf_chk #(.BANK_W(BANK_W), .CHIP_ID(CHIP_ID)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .wr_en        (wr_en),
  .rd_en        (rd_en),
  .addr         (addr),
  .wdata        (wdata),
  .rdata        (rdata),
  .idx_q        (idx_q),
  .bank_new     (bank_new),
  .seq_in_reset (seq_in_reset),
  .clk_double   (clk_double),
  .mem_bank     (mem_bank)
);

// File: tb/sim_seq_regfile.sv
`timescale 1ns/1ps
module sim_seq_regfile;
  localparam int         BANK_W  = 4;
  localparam logic [7:0] CHIP_ID = 8'hD3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic rd_en = 1'b0;
  logic addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic seq_in_reset;
  logic clk_double;
  logic [BANK_W-1:0] mem_bank;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } exp_item_t;
  exp_item_t sb_q[$];
  logic rd_pend = 1'b0;

  always #2 clk = ~clk;

  seq_regfile #(.STD_COUNT(4), .BANK_W(BANK_W), .CHIP_ID(CHIP_ID)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .seq_in_reset(seq_in_reset),
    .clk_double(clk_double), .mem_bank(mem_bank)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, input logic [7:0] exp, input string tag);
    exp_item_t it;
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wreg(input logic [7:0] ix, input logic [7:0] d);
    wr(1'b0, ix);
    wr(1'b1, d);
  endtask

  task automatic rreg(input logic [7:0] ix, input logic [7:0] exp, input string tag);
    wr(1'b0, ix);
    rd(1'b1, exp, tag);
  endtask

  always @(posedge clk) rd_pend <= rd_en;

  always @(negedge clk) begin
    #1;
    if (rd_pend) begin
      if (sb_q.size() == 0) begin
        chk("scoreboard underflow", 8'hxx, 8'h00);
      end else begin
        exp_item_t it;
        it = sb_q.pop_front();
        chk(it.tag, rdata, it.exp);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 seq_in_reset", 8'(seq_in_reset), 8'h00);
    chk("R1 clk_double", 8'(clk_double), 8'h00);
    chk("R1 mem_bank", 8'(mem_bank), 8'h02);
    chk("R1 rdata", rdata, 8'h00);
    rd(1'b0, 8'h00, "R1 R2 index after reset");
    rreg(8'h0D, 8'h00, "R1 old 0D cleared");
    rreg(8'h0E, 8'h00, "R1 old 0E cleared");

    // R3 run control
    wreg(8'h00, 8'h01);
    chk("R3 enter reset", 8'(seq_in_reset), 8'h01);
    rd(1'b1, 8'h01, "R3 readback 1");
    wreg(8'h00, 8'h03);
    chk("R3 leave reset", 8'(seq_in_reset), 8'h00);
    wreg(8'h00, 8'hFD);
    chk("R3 bit1 clear", 8'(seq_in_reset), 8'h01);
    rd(1'b1, 8'h01, "R3 upper bits zero");
    wreg(8'h00, 8'h03);
    chk("R3 run again", 8'(seq_in_reset), 8'h00);

    // R4 standard group
    wreg(8'h01, 8'h01);
    wreg(8'h02, 8'h0F);
    wreg(8'h03, 8'h00);
    wreg(8'h04, 8'h0E);
    rreg(8'h01, 8'h01, "R4 std 1");
    rreg(8'h02, 8'h0F, "R4 std 2");
    rreg(8'h03, 8'h00, "R4 std 3");
    rreg(8'h04, 8'h0E, "R4 std 4");
    rd(1'b0, 8'h04, "R2 index readback");
    wreg(8'h03, 8'hA5);
    rreg(8'h03, 8'hA5, "R4 std 3 full byte");
    rreg(8'h02, 8'h0F, "R4 std 2 kept");

    // R7 R8 R9 old set writes
    wreg(8'h0D, 8'h5B);
    chk("R9 old 0D no effect", 8'(clk_double), 8'h00);
    wreg(8'h0E, 8'h33);
    chk("R8 old 0E no effect", 8'(mem_bank), 8'h02);
    rreg(8'h0D, 8'h5B, "R7 old 0D readback");

    // R5 id read selects new set
    rreg(8'h0B, CHIP_ID, "R5 chip id");
    rreg(8'h0D, 8'h00, "R5 R7 new 0D fresh");
    wr(1'b1, 8'h01);
    chk("R9 new 0D clk_double", 8'(clk_double), 8'h01);
    wreg(8'h0E, 8'h05);
    chk("R8 mem_bank 05", 8'(mem_bank), 8'h07);
    wr(1'b1, 8'hF3);
    chk("R8 upper bits ignored", 8'(mem_bank), 8'h01);
    rd(1'b1, 8'hF3, "R7 new 0E readback");

    // R6 id write selects old set
    wreg(8'h0B, 8'hFF);
    rreg(8'h0E, 8'h33, "R6 R7 old 0E kept");
    rreg(8'h0D, 8'h5B, "R6 R7 old 0D kept");
    chk("R6 clk_double held", 8'(clk_double), 8'h01);
    chk("R6 mem_bank held", 8'(mem_bank), 8'h01);
    rreg(8'h0B, CHIP_ID, "R6 data discarded");
    rreg(8'h0E, 8'hF3, "R7 new 0E back");
    wreg(8'h0D, 8'h00);
    chk("R9 clk_double off", 8'(clk_double), 8'h00);

    // R10 unused index
    wreg(8'h07, 8'hAA);
    chk("R10 mem_bank", 8'(mem_bank), 8'h01);
    chk("R10 clk_double", 8'(clk_double), 8'h00);
    chk("R10 seq_in_reset", 8'(seq_in_reset), 8'h00);
    rd(1'b1, 8'h00, "R10 read zero");
    wreg(8'h20, 8'h55);
    rd(1'b1, 8'h00, "R10 high index zero");

    // R11 rdata holds without read
    wreg(8'h01, 8'h77);
    chk("R11 rdata held", rdata, 8'h00);

    repeat (4) @(negedge clk);
    if (sb_q.size() != 0) chk("scoreboard drained", 8'(sb_q.size()), 8'h00);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule